// File: doc/BRIEF.md
# Two-Dimensional Block Parity Codec

The codec protects a short block of data words with parity along two axes. Words enter one per clock as the rows of a matrix. A parity bit is kept for every bit column across all rows of the block, and a parity bit can also be formed across each row. A burst of neighbouring bit flips inside one word therefore lands in several separate column checks rather than cancelling out, and the row bits locate a fault in the second dimension.

In generate mode each data row is forwarded one cycle later with its row parity bit. After the last data row, the block appends one extra row that holds the column parity bits. In check mode the block takes the data rows followed by that parity row, with `in_last` on the parity row. It recomputes every parity, then reports a per-column mismatch vector, a per-row mismatch vector and one summary error flag, all strobed with `done`.

The control is a three-state machine. ST_IDLE waits for the first beat of a block. ST_BODY accumulates the remaining beats. ST_FLUSH exists only in generate mode and emits the parity row. The transitions are as follows. IDLE→BODY on a beat without last. IDLE or BODY→FLUSH on a last beat in generate mode. IDLE or BODY→IDLE on a last beat in check mode. FLUSH→IDLE always.

Top module: `blk_parity_codec`

## Requirements
- R1: Every generated parity bit makes the modulo-2 sum of the bits it guards plus itself equal `odd_sel`: 0 gives even parity, 1 gives odd parity. For example, with odd parity the row 01101 gets a row bit of 0.
- R2: In generate mode each accepted row appears on `out_data` one cycle after its beat, with `out_valid`=1, `out_last`=0, and `out_rowpar` equal to the row parity of that row.
- R3: In generate mode, on the cycle after the beat that carries `in_last`, the block emits the column parity row. In that cycle `out_valid`=1, `out_last`=1 and `done`=1, and `out_rowpar` holds the parity across the column parity bits.
- R4: `gen_mode` (1 = generate, 0 = check) and `odd_sel` are captured on the first beat of a block and held for the whole block. Later changes to these inputs within the block have no effect. In generate mode the sender leaves the cycle after a last beat idle.
- R5: In check mode, one cycle after the beat that carries `in_last` (the parity row), `done`=1. Bit i of `col_err` is 1 exactly when bit i summed over all rows, the parity row included, differs from `odd_sel`.
- R6: In check mode, bit r of `row_err` is 1 exactly when data row r (r counted from 0 in arrival order) plus its `in_rowpar` sums to a value other than `odd_sel`. The `in_rowpar` of the parity row is ignored.
- R7: `err` is the OR of all bits of `col_err` and `row_err`. All three outputs are zero whenever `done` is 0, and they are zero in generate mode.
- R8: A single flipped data bit raises one column and one row mismatch. Two flipped adjacent bits in one row raise two column mismatches and no row mismatch. Two flipped bits in one column raise no column mismatch and two row mismatches.
- R9: The accumulators restart on the first beat after reset or after a last beat, so back-to-back blocks are checked independently.
- R10: After reset, `out_valid`, `out_last`, `done`, `err`, `col_err`, `row_err`, `out_data` and `out_rowpar` are all 0.
- R11: In check mode `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_mode | input | 1 | 1 = generate, 0 = check; sampled on the first beat |
| odd_sel | input | 1 | 1 = odd parity, 0 = even; sampled on the first beat |
| in_valid | input | 1 | Input beat present |
| in_last | input | 1 | Final beat of the block |
| in_data | input | W | Row word |
| in_rowpar | input | 1 | Row parity bit of the row (check mode) |
| out_valid | output | 1 | Output row present (generate mode) |
| out_last | output | 1 | Output row is the column parity row |
| out_data | output | W | Forwarded row or column parity row |
| out_rowpar | output | 1 | Row parity bit of the output row |
| done | output | 1 | One-cycle end-of-block strobe |
| col_err | output | W | Per-column mismatch vector |
| row_err | output | ROWS | Per-row mismatch vector |
| err | output | 1 | Any mismatch |

## Verification
Random blocks of one to four rows run in both modes and with both parity senses, and the bench compares the results with its own parity functions. Directed faults separate the three detection cases. A lone flip marks one row and one column. A flipped adjacent pair in one row shows up only in the column vector, which shows the burst does not cancel. A flipped pair in one column shows up only in the row vector. Toggling the mode inputs inside a block, sending blocks back to back and randomising the ignored row bit of the parity row test mode capture, accumulator restart and that the ignored bit really has no effect.

// File: rtl/blkpar_pkg.sv
package blkpar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_FLUSH = 2'd2
    } blkpar_state_e;
endpackage

// File: rtl/blkpar_row_calc.sv
module blkpar_row_calc #(
    parameter int W = 5
) (
    input  logic [W-1:0] bits,
    input  logic         extra,
    input  logic         odd,
    output logic         result
);
    // Sum of bits and extra, compared against the target parity sense.
    assign result = (^bits) ^ extra ^ odd;
endmodule

// File: rtl/blkpar_col_acc.sv
module blkpar_col_acc #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] d,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] acc_nxt
);
    for (genvar i = 0; i < W; i++) begin : g_col
        assign acc_nxt[i] = (restart ? 1'b0 : acc_q[i]) ^ d[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  acc_q[i] <= 1'b0;
            else if (en) acc_q[i] <= acc_nxt[i];
        end
    end
endmodule

// File: rtl/blk_parity_codec.sv
module blk_parity_codec
    import blkpar_pkg::*;
#(
    parameter int W       = 5,
    parameter int ROWS    = 4,
    parameter bit ROW_PAR = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gen_mode,
    input  logic            odd_sel,
    input  logic            in_valid,
    input  logic            in_last,
    input  logic [W-1:0]    in_data,
    input  logic            in_rowpar,
    output logic            out_valid,
    output logic            out_last,
    output logic [W-1:0]    out_data,
    output logic            out_rowpar,
    output logic            done,
    output logic [W-1:0]    col_err,
    output logic [ROWS-1:0] row_err,
    output logic            err
);
    localparam int IDXW = $clog2(ROWS + 1);

    blkpar_state_e   state_q, state_d;
    logic            gen_q, odd_q;
    logic [IDXW-1:0] idx_q, idx_cur;
    logic [ROWS-1:0] racc_q, racc_nxt;
    logic [W-1:0]    acc_q, acc_nxt, tail_row;
    logic            beat, first, gen_eff, odd_eff;
    logic            row_mism, row_gen, tail_rp;

    assign beat     = in_valid && (state_q != ST_FLUSH);
    assign first    = beat && (state_q == ST_IDLE);
    assign gen_eff  = first ? gen_mode : gen_q;
    assign odd_eff  = first ? odd_sel  : odd_q;
    assign idx_cur  = first ? '0 : idx_q;
    assign tail_row = acc_q ^ {W{odd_q}};

    blkpar_col_acc #(.W(W)) u_col_acc (
        .clk(clk), .rst_n(rst_n), .en(beat), .restart(first),
        .d(in_data), .acc_q(acc_q), .acc_nxt(acc_nxt)
    );

    blkpar_row_calc #(.W(W)) u_row_chk (
        .bits(in_data), .extra(in_rowpar), .odd(odd_eff), .result(row_mism)
    );
    blkpar_row_calc #(.W(W)) u_row_gen (
        .bits(in_data), .extra(1'b0), .odd(odd_eff), .result(row_gen)
    );
    blkpar_row_calc #(.W(W)) u_row_tail (
        .bits(tail_row), .extra(1'b0), .odd(odd_q), .result(tail_rp)
    );

    if (ROW_PAR) begin : g_rowpar
        always_comb begin
            for (int r = 0; r < ROWS; r++) begin
                racc_nxt[r] = (first ? 1'b0 : racc_q[r])
                            | (!in_last && row_mism && (idx_cur == IDXW'(r)));
            end
        end
    end else begin : g_norowpar
        assign racc_nxt = '0;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_BODY: begin
                if (beat) begin
                    if (in_last) state_d = gen_eff ? ST_FLUSH : ST_IDLE;
                    else         state_d = ST_BODY;
                end
            end
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and block context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gen_q   <= 1'b0;
            odd_q   <= 1'b0;
            idx_q   <= '0;
            racc_q  <= '0;
        end else begin
            state_q <= state_d;
            if (beat) begin
                gen_q  <= gen_eff;
                odd_q  <= odd_eff;
                racc_q <= racc_nxt;
                idx_q  <= (idx_cur == IDXW'(ROWS)) ? idx_cur : idx_cur + 1'b1;
            end
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            out_data   <= '0;
            out_rowpar <= 1'b0;
            done       <= 1'b0;
            col_err    <= '0;
            row_err    <= '0;
            err        <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            done      <= 1'b0;
            col_err   <= '0;
            row_err   <= '0;
            err       <= 1'b0;
            if (state_q == ST_FLUSH) begin
                out_valid  <= 1'b1;
                out_last   <= 1'b1;
                out_data   <= tail_row;
                out_rowpar <= ROW_PAR ? tail_rp : 1'b0;
                done       <= 1'b1;
            end else if (beat && gen_eff) begin
                out_valid  <= 1'b1;
                out_data   <= in_data;
                out_rowpar <= ROW_PAR ? row_gen : 1'b0;
            end else if (beat && in_last) begin
                done    <= 1'b1;
                col_err <= acc_nxt ^ {W{odd_eff}};
                row_err <= racc_nxt;
                err     <= (|(acc_nxt ^ {W{odd_eff}})) | (|racc_nxt);
            end
        end
    end

    // R7: the error flag only appears together with the done strobe
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R7: mismatch vectors stay quiet outside the done strobe
    a_r7_quiet_vectors: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (col_err == '0 && row_err == '0));
    // R3: the flush state puts out the tagged parity row
    a_r3_flush_row: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (out_valid && out_last && done));
    // R2: a generate beat is forwarded unchanged on the next cycle
    a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && gen_eff) |=> (out_valid && !out_last && out_data == $past(in_data)));
    // R11: a check beat produces no output row
    a_r11_check_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !gen_eff) |=> !out_valid);
endmodule

// File: tb/test_blk_parity_codec.sv
module test_blk_parity_codec;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 5;
    localparam int ROWS = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic gen_mode = 1'b0, odd_sel = 1'b0, in_valid = 1'b0, in_last = 1'b0, in_rowpar = 1'b0;
    logic [W-1:0] in_data = '0;
    logic out_valid, out_last, out_rowpar, done, err;
    logic [W-1:0] out_data, col_err;
    logic [ROWS-1:0] row_err;

    int checks = 0, errors = 0;
    logic [W-1:0] rw [ROWS+1];
    logic         rp [ROWS+1];

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_parity_codec #(.W(W), .ROWS(ROWS), .ROW_PAR(1'b1)) i_blk_parity_codec (
        .clk(clk), .rst_n(rst_n), .gen_mode(gen_mode), .odd_sel(odd_sel),
        .in_valid(in_valid), .in_last(in_last), .in_data(in_data), .in_rowpar(in_rowpar),
        .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
        .out_rowpar(out_rowpar), .done(done), .col_err(col_err),
        .row_err(row_err), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] col_par(input int n, input bit odd);
        logic [W-1:0] s = '0;
        for (int j = 0; j < n; j++) s ^= rw[j];
        return s ^ {W{odd}};
    endfunction

    function automatic logic [W-1:0] col_exp(input int n, input bit odd);
        logic [W-1:0] s = '0;
        for (int j = 0; j <= n; j++) s ^= rw[j];
        return s ^ {W{odd}};
    endfunction

    function automatic logic [ROWS-1:0] row_exp(input int n, input bit odd);
        logic [ROWS-1:0] v = '0;
        for (int j = 0; j < n; j++) v[j] = (^rw[j]) ^ rp[j] ^ odd;
        return v;
    endfunction

    // Generate-mode block; rw[0..n-1] preloaded. Mode inputs toggle after the first beat (R4).
    task automatic run_gen(input int n, input bit odd);
        logic [W-1:0] cp;
        for (int j = 0; j < n; j++) begin
            in_valid = 1'b1; in_last = (j == n-1); in_data = rw[j];
            gen_mode = (j == 0); odd_sel = (j == 0) ? odd : ~odd;
            @(posedge clk); #1;
            chk(out_valid && !out_last && out_data == rw[j], "R2 R4 forward", out_data, rw[j]);
            chk(out_rowpar == ((^rw[j]) ^ odd), "R1 row bit", out_rowpar, (^rw[j]) ^ odd);
            if (j == n-1) in_valid = 1'b0;
        end
        cp = col_par(n, odd);
        @(posedge clk); #1;
        chk(out_valid && out_last && done, "R3 tail strobe", {out_valid, out_last, done}, 3'b111);
        chk(out_data == cp, "R1 R3 column row", out_data, cp);
        chk(out_rowpar == ((^cp) ^ odd), "R3 corner bit", out_rowpar, (^cp) ^ odd);
        chk(!err && col_err == '0 && row_err == '0, "R7 gen quiet", {err, col_err, row_err}, 0);
    endtask

    // Check-mode block; rw[0..n] (parity row at n) and rp preloaded. Back-to-back allowed.
    task automatic run_chk(input int n, input bit odd, input string tag);
        logic [W-1:0] ce; logic [ROWS-1:0] re;
        ce = col_exp(n, odd); re = row_exp(n, odd);
        for (int j = 0; j <= n; j++) begin
            in_valid = 1'b1; in_last = (j == n); in_data = rw[j]; in_rowpar = rp[j];
            gen_mode = (j != 0); odd_sel = (j == 0) ? odd : ~odd;
            @(posedge clk); #1;
            chk(!out_valid, "R11 no output in check", out_valid, 0);
            if (j < n) chk(!done && !err, "R7 quiet mid-block", {done, err}, 0);
        end
        in_valid = 1'b0;
        chk(done, {"R5 done ", tag}, done, 1);
        chk(col_err == ce, {"R5 col_err ", tag}, col_err, ce);
        chk(row_err == re, {"R6 row_err ", tag}, row_err, re);
        chk(err == ((|ce) | (|re)), {"R7 err ", tag}, err, (|ce) | (|re));
    endtask

    // Fill n data rows with valid parity plus parity row at index n (its row bit random, ignored: R6).
    task automatic build(input int n, input bit odd);
        for (int j = 0; j < n; j++) begin
            rw[j] = W'($urandom);
            rp[j] = (^rw[j]) ^ odd;
        end
        rw[n] = col_par(n, odd);
        rp[n] = 1'($urandom);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'h2d_5eed);
        #(CLK_PERIOD * 3);
        #1;
        chk(!out_valid && !out_last && !done && !err && col_err == '0 && row_err == '0
            && out_data == '0 && !out_rowpar, "R10 reset state", {out_valid, done, err}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // Directed R1 example: 01101 with odd parity gets row bit 0
        rw[0] = 5'b01101;
        run_gen(1, 1'b1);

        // Clean check blocks, back to back (R9)
        for (int k = 0; k < 6; k++) begin
            int n = 1 + int'($urandom % ROWS);
            bit odd = 1'($urandom);
            build(n, odd);
            run_chk(n, odd, "R9 clean");
        end

        // Directed faults (R8)
        build(4, 1'b0);
        rw[2][3] = ~rw[2][3];
        run_chk(4, 1'b0, "single");
        chk($countones(col_err) == 1 && $countones(row_err) == 1, "R8 single flip",
            {col_err, row_err}, 0);

        build(4, 1'b1);
        rw[1][1] = ~rw[1][1]; rw[1][2] = ~rw[1][2];
        run_chk(4, 1'b1, "row pair");
        chk(col_err == 5'b00110 && row_err == '0, "R8 adjacent pair in row",
            {col_err, row_err}, {5'b00110, 4'b0000});

        build(3, 1'b0);
        rw[0][4] = ~rw[0][4]; rw[2][4] = ~rw[2][4];
        run_chk(3, 1'b0, "col pair");
        chk(col_err == '0 && row_err == 4'b0101, "R8 pair in column",
            {col_err, row_err}, {5'b00000, 4'b0101});

        // Random generate and random faulty check blocks
        for (int k = 0; k < 20; k++) begin
            int n = 1 + int'($urandom % ROWS);
            bit odd = 1'($urandom);
            if ($urandom % 2 == 0) begin
                for (int j = 0; j < n; j++) rw[j] = W'($urandom);
                run_gen(n, odd);
            end else begin
                build(n, odd);
                for (int f = 0; f < 2; f++) begin
                    int r = int'($urandom % (n + 1));
                    if ($urandom % 3 == 0) rp[r] = ~rp[r];
                    else rw[r] ^= W'(1 << ($urandom % W));
                end
                run_chk(n, odd, "random");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule